// File: doc/BRIEF.md
# Vector Indexed Load Address Sequencer

This block walks through the elements of a vector load, one element at a time, and produces the effective address for each element. On a start pulse it captures the vector length, a 64-bit base value, the offset element width, the extension mode, an optional immediate and the access size. For each element it reads the packed offset register region through a combinational register-read port, extracts that element's offset, extends it to 64 bits, and adds it to the base. In immediate mode it instead adds a fixed immediate to the base and ignores the offset width.

Each element becomes one read request on a simple valid/ready memory port. Only one request is outstanding at a time. When the read data comes back it is passed straight to a downstream formatter, together with the destination element index. After the last element returns, the block raises a one-cycle done pulse and becomes idle again.

Top module: `vidx_addr_seq`

## Requirements
- R1: After reset, `busy`, `done`, `req_valid` and `out_valid` are all low.
- R2: A start with `vl` = 0 issues no request. `done` is high in the cycle after the start edge and low in the cycle after that.
- R3: A start with `vl` = N (1 to 64) issues exactly N requests, for elements 0 to N-1 in ascending order.
- R4: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` does not change.
- R5: After a request is accepted, `req_valid` stays low until `rd_valid` returns for that element.
- R6: In indexed mode, the address for element i is the captured base plus the zero-extended offset. The offset width is selected by `src_ew`: 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. Element i occupies bits [(i*W) mod 64 +: W] of offset register floor(i*W/64), and `offreg_idx` presents that register number.
- R7: When `sext` is 1 in indexed mode, the offset is sign-extended from its width W to 64 bits before the add.
- R8: When `imm_mode` is 1, the address is the captured base plus `imm`, whatever the values of `src_ew`, `sext` and the offset registers.
- R9: In the cycle in which `rd_valid` returns for an element, `out_valid` is high, `out_data` equals `rd_data`, and `out_idx` equals that element's index.
- R10: `req_size` equals the access size captured at start, for every request of the operation.
- R11: `done` pulses for one cycle in the cycle after the last element's data returns, with `busy` low. A start that arrives while busy is ignored.
- R12: The configuration inputs are captured at start. Changing them during the operation does not affect its addresses, size or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| vl | input | 7 | Vector length, 0 to 64 |
| src_ew | input | 2 | Offset element width code |
| sext | input | 1 | Sign-extend offsets |
| imm_mode | input | 1 | Use immediate instead of per-element offsets |
| imm | input | 64 | Immediate offset |
| base | input | 64 | Scalar base value |
| acc_size | input | 2 | Memory access size code |
| offreg_idx | output | 6 | Offset register number being read |
| offreg_data | input | 64 | Contents of that offset register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts request |
| req_addr | output | 64 | Effective address |
| req_size | output | 2 | Access size |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 64 | Read data |
| out_valid | output | 1 | Data to formatter valid |
| out_data | output | 64 | Data to formatter |
| out_idx | output | 6 | Destination element index |

## Verification
The bench targets the corners of the offset extraction: elements that sit at the top of a register at each width, and offsets whose sign bit is set. A design with the wrong shift or register number would fetch a neighbour's offset, and one that ignored the width in the sign extension would add a huge or truncated value. Lengths of 0, 1 and 64 find counting errors, such as a spurious request for a zero-length vector or an extra or missing final element. Memory stalls, late returns, stray starts and configuration pins scrambled mid-run find a request that drops or moves under backpressure, a second outstanding request, or settings that were not captured.

// File: rtl/vidx_addr_seq.sv
module vidx_addr_seq #(
  parameter int MAXVL = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [$clog2(MAXVL):0]   vl,
  input  logic [1:0]               src_ew,
  input  logic                     sext,
  input  logic                     imm_mode,
  input  logic [63:0]              imm,
  input  logic [63:0]              base,
  input  logic [1:0]               acc_size,
  output logic [$clog2(MAXVL)-1:0] offreg_idx,
  input  logic [63:0]              offreg_data,
  output logic                     busy,
  output logic                     done,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [63:0]              req_addr,
  output logic [1:0]               req_size,
  input  logic                     rd_valid,
  input  logic [63:0]              rd_data,
  output logic                     out_valid,
  output logic [63:0]              out_data,
  output logic [$clog2(MAXVL)-1:0] out_idx
);
  localparam int RW  = $clog2(MAXVL);
  localparam int VLW = RW + 1;
  localparam int BW  = VLW + 3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_FIN} st_t;

  st_t            st;
  logic [VLW-1:0] src_i, dst_j, vl_q;
  logic [1:0]     ew_q, size_q;
  logic           se_q, im_q;
  logic [63:0]    imm_q, base_q;

  logic [BW-1:0]  byte_pos;
  logic [63:0]    lane, offs;

  assign byte_pos   = BW'(src_i) << ew_q;
  assign offreg_idx = RW'(byte_pos >> 3);
  assign lane       = offreg_data >> {byte_pos[2:0], 3'b000};

  always_comb begin
    case (ew_q)
      2'd0:    offs = {{56{se_q & lane[7]}},  lane[7:0]};
      2'd1:    offs = {{48{se_q & lane[15]}}, lane[15:0]};
      2'd2:    offs = {{32{se_q & lane[31]}}, lane[31:0]};
      default: offs = lane;
    endcase
  end

  assign req_addr  = base_q + (im_q ? imm_q : offs);
  assign req_size  = size_q;
  assign req_valid = (st == S_REQ);
  assign busy      = (st == S_REQ) || (st == S_WAIT);
  assign done      = (st == S_FIN);
  assign out_valid = (st == S_WAIT) && rd_valid;
  assign out_data  = rd_data;
  assign out_idx   = RW'(dst_j);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      src_i  <= '0;
      dst_j  <= '0;
      vl_q   <= '0;
      ew_q   <= '0;
      size_q <= '0;
      se_q   <= 1'b0;
      im_q   <= 1'b0;
      imm_q  <= '0;
      base_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          vl_q   <= vl;
          ew_q   <= src_ew;
          se_q   <= sext;
          im_q   <= imm_mode;
          imm_q  <= imm;
          base_q <= base;
          size_q <= acc_size;
          src_i  <= '0;
          dst_j  <= '0;
          st     <= (vl == '0) ? S_FIN : S_REQ;
        end
        S_REQ: if (req_ready) st <= S_WAIT;
        S_WAIT: if (rd_valid) begin
          src_i <= src_i + 1'b1;
          dst_j <= dst_j + 1'b1;
          st    <= (src_i + 1'b1 >= vl_q || dst_j + 1'b1 >= vl_q) ? S_FIN : S_REQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  a_r5_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  a_r3_index_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (src_i == dst_j && src_i < vl_q));

  a_r2_zero_length: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && vl == '0) |=> (done && !req_valid));

  a_r11_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && VLW'(out_idx) + 1'b1 == vl_q) |=> (done && !busy));

  a_r10_size_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid)) |-> $stable(req_size));
endmodule

// File: tb/vidx_addr_seq_tb.sv
module vidx_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl_i = '0;
  logic [1:0]  ew_i = '0;
  logic        se_i = 1'b0;
  logic        im_i = 1'b0;
  logic [63:0] imm_i = '0;
  logic [63:0] base_i = '0;
  logic [1:0]  size_i = '0;
  logic [5:0]  offreg_idx;
  logic [63:0] offreg_data;
  logic        busy, done, req_valid, out_valid;
  logic        req_ready = 1'b0;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic [63:0] req_addr, out_data;
  logic [1:0]  req_size;
  logic [5:0]  out_idx;

  logic [63:0] regs [64];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign offreg_data = regs[offreg_idx];

  vidx_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl_i), .src_ew(ew_i),
    .sext(se_i), .imm_mode(im_i), .imm(imm_i), .base(base_i), .acc_size(size_i),
    .offreg_idx(offreg_idx), .offreg_data(offreg_data), .busy(busy), .done(done),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .rd_valid(rd_valid), .rd_data(rd_data),
    .out_valid(out_valid), .out_data(out_data), .out_idx(out_idx)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_addr(int k, int ew, bit se, bit im,
                                           logic [63:0] iv, logic [63:0] b);
    int w = 8 << ew;
    int bp = k * w;
    logic [63:0] raw, msk, o;
    if (im) return b + iv;
    raw = regs[bp / 64] >> (bp % 64);
    msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    o = raw & msk;
    if (se && w < 64 && raw[w-1]) o = o | ~msk;
    return b + o;
  endfunction

  task automatic scramble();
    vl_i   = 7'($urandom_range(0, 64));
    ew_i   = 2'($urandom);
    se_i   = 1'($urandom);
    im_i   = 1'($urandom);
    imm_i  = {$urandom, $urandom};
    base_i = {$urandom, $urandom};
    size_i = 2'($urandom);
  endtask

  task automatic run_op(int vl, int ew, bit se, bit im, logic [63:0] iv,
                        logic [63:0] b, int sz);
    string tag;
    logic [63:0] a0, ea, d;
    tag = im ? "R8" : (se ? "R7" : "R6");
    @(negedge clk);
    vl_i = 7'(vl); ew_i = 2'(ew); se_i = se; im_i = im;
    imm_i = iv; base_i = b; size_i = 2'(sz); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    scramble();
    if (vl == 0) begin
      chk(done && !req_valid, "R2 zero-length done", {62'd0, done, req_valid}, 64'd2);
      @(negedge clk);
      chk(!done && !busy && !req_valid, "R2 single pulse", {63'd0, done}, 64'd0);
      return;
    end
    for (int k = 0; k < vl; k++) begin
      int stalls = $urandom_range(0, 2);
      int lat = $urandom_range(0, 2);
      ea = exp_addr(k, ew, se, im, iv, b);
      for (int s = 0; s < stalls; s++) begin
        req_ready = 1'b0;
        a0 = req_addr;
        if ($urandom_range(0, 1) == 1) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(req_valid && req_addr == a0, "R4 hold under stall", req_addr, a0);
        chk(busy, "R11 start ignored while busy", {63'd0, busy}, 64'd1);
      end
      chk(req_valid, "R3 request present", {63'd0, req_valid}, 64'd1);
      chk(req_addr == ea, tag, req_addr, ea);
      chk(req_size == 2'(sz), "R10 R12 size", {62'd0, req_size}, 64'(sz));
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      chk(!req_valid && busy, "R5 no second request", {63'd0, req_valid}, 64'd0);
      repeat (lat) begin
        @(negedge clk);
        chk(!req_valid, "R5 waiting for data", {63'd0, req_valid}, 64'd0);
      end
      d = {$urandom, $urandom};
      rd_valid = 1'b1;
      rd_data = d;
      #1;
      chk(out_valid && out_data == d, "R9 data pass", out_data, d);
      chk(out_idx == 6'(k), "R9 R3 element index", {58'd0, out_idx}, 64'(k));
      @(negedge clk);
      rd_valid = 1'b0;
    end
    chk(done && !busy, "R11 done pulse", {62'd0, done, busy}, 64'd2);
    @(negedge clk);
    chk(!done && !req_valid, "R3 R11 no extra request", {62'd0, done, req_valid}, 64'd0);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < 64; r++) regs[r] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req_valid && !out_valid, "R1 reset state",
        {60'd0, busy, done, req_valid, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !req_valid, "R1 idle after reset", {63'd0, busy}, 64'd0);

    run_op(0, 2, 1'b1, 1'b0, 64'd0, 64'h1000, 1);
    run_op(1, 0, 1'b0, 1'b0, 64'd0, 64'h2000, 0);
    regs[0] = 64'h80ff_7f01_8000_0081;
    regs[7] = 64'h8000_0000_0000_00ff;
    run_op(8, 0, 1'b1, 1'b0, 64'd0, 64'h4000, 0);
    run_op(8, 0, 1'b0, 1'b0, 64'd0, 64'h4000, 0);
    run_op(4, 1, 1'b1, 1'b0, 64'd0, 64'hffff_ffff_ffff_fff0, 1);
    run_op(4, 2, 1'b1, 1'b0, 64'd0, 64'h10_0000, 2);
    run_op(64, 3, 1'b0, 1'b0, 64'd0, 64'h8000_0000, 3);
    run_op(64, 0, 1'b1, 1'b0, 64'd0, 64'h3_0000, 0);
    run_op(5, 3, 1'b1, 1'b1, 64'h0000_0000_0000_0040, 64'h5000, 3);
    run_op(3, 0, 1'b1, 1'b1, 64'hffff_ffff_ffff_fff8, 64'h6000, 2);
    for (int t = 0; t < 30; t++) begin
      for (int r = 0; r < 64; r++) regs[r] = {$urandom, $urandom};
      run_op($urandom_range(0, 64), $urandom_range(0, 3), 1'($urandom), 1'($urandom_range(0, 4) == 0),
             {$urandom, $urandom}, {$urandom, $urandom}, $urandom_range(0, 3));
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule